// File: doc/BRIEF.md
# SYSREF Multi-Stage Synchronization Sequencer

This block takes a SYSREF reference strobe, already sampled in the device clock domain, and runs a four-step alignment sequence over it. Each step starts on a qualified rising SYSREF edge and produces a one-cycle strobe for its group of clock dividers. Step one resets the device clock dividers, step two resynchronizes them, step three aligns the high-speed digital dividers, and step four aligns the NCOs, the RF PLL phase logic and a local LMFC counter.

Resetting the divider in step one upsets the clock that follows it, so edges that arrive inside a programmable blanking window after that step are discarded. A small saturating counter records how many were discarded. When all four steps are complete, the block keeps watching a continuous SYSREF. It compares each later rising edge with the phase of the LMFC counter and flags any edge that does not fall on an LMFC boundary.

Top module: `sysref_sync_seq`

## Requirements
- R1: After reset, `stage_pulse` is 0, and `done`, `lmfc_tick`, `phase_live`, `phase_err` and `ignored_cnt` are all 0.
- R2: Each qualified rising edge of `sysref_in` produces one pulse on `stage_pulse`, one cycle long. The bits fire in the order bit0, bit1, bit2, bit3 for steps one to four. The pulse is visible in the cycle after the third rising clock edge at which `sysref_in` is sampled high.
- R3: A `sysref_in` held high for many cycles counts as a single edge. A further step needs `sysref_in` to go low for at least one cycle and then high again.
- R4: After the step-one pulse, a blanking window of `blank_len` cycles begins. Rising edges that act inside this window cause no pulse. Each one increments `ignored_cnt`, which saturates at its all-ones value.
- R5: `done` goes high in the same cycle as the bit3 pulse and stays high while `en` is held.
- R6: `lmfc_tick` is high in the same cycle as the bit3 pulse. After that it is high once every `lmfc_period` cycles.
- R7: After `done`, each rising SYSREF edge is compared with the LMFC phase. An edge whose acting clock edge falls exactly a multiple of `lmfc_period` cycles after the step-four acting edge is in phase. For an in-phase edge `phase_live` reads 0. For any other edge `phase_live` reads 1 and `phase_err` is set.
- R8: `phase_err` stays set until `err_clr` is sampled high with no new mismatch in the same cycle. When both happen in the same cycle, the mismatch wins.
- R9: While `en` is low, `done` and the stage count are cleared and no pulses occur. When `en` returns high, the sequence restarts at step one.
- R10: Once `done` is high, further SYSREF edges produce no `stage_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Sequencer enable; low returns it to idle |
| sysref_in | input | 1 | SYSREF level, synchronized inside the block |
| lmfc_period | input | PER_W | LMFC period in clock cycles |
| blank_len | input | BLANK_W | Blanking length after step one, in cycles |
| err_clr | input | 1 | Clear for the sticky phase error |
| stage_pulse | output | 4 | One-cycle step strobes, bit0 = step one |
| done | output | 1 | All four steps complete |
| lmfc_tick | output | 1 | LMFC boundary marker after alignment |
| phase_live | output | 1 | Result of the latest phase comparison (1 = off phase) |
| phase_err | output | 1 | Sticky phase error |
| ignored_cnt | output | IGN_W | Saturating count of edges discarded during blanking |

## Verification
The assertions assume that `lmfc_period` and `blank_len` stay constant while a sequence is running. They also assume that `lmfc_period` is at least 2. The bench sets both values only while `en` is low or before the first edge, and it uses a period of 10 cycles. Every SYSREF edge the bench drives is preceded by at least one low cycle. It also keeps `err_clr` low except during the cycle in which it tests clearing.

// File: rtl/sysref_sync_seq.sv
module sysref_sync_seq #(
  parameter int PER_W   = 8,
  parameter int BLANK_W = 12,
  parameter int IGN_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               sysref_in,
  input  logic [PER_W-1:0]   lmfc_period,
  input  logic [BLANK_W-1:0] blank_len,
  input  logic               err_clr,
  output logic [3:0]         stage_pulse,
  output logic               done,
  output logic               lmfc_tick,
  output logic               phase_live,
  output logic               phase_err,
  output logic [IGN_W-1:0]   ignored_cnt
);

  localparam logic [IGN_W-1:0] IGN_MAX = '1;

  logic [2:0]         sr_q;
  logic [1:0]         stage_q;
  logic [BLANK_W-1:0] blank_q;
  logic [PER_W-1:0]   lmfc_q;

  wire rise      = sr_q[1] & ~sr_q[2];
  wire blanking  = blank_q != '0;
  wire seq_edge  = en & rise & ~done & ~blanking;
  wire ign_edge  = en & rise & ~done & blanking;
  wire mon_edge  = en & rise & done;
  wire lmfc_last = lmfc_q >= lmfc_period - PER_W'(1);
  wire last_step = seq_edge & (stage_q == 2'd3);

  assign lmfc_tick = done & (lmfc_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[1:0], sysref_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q     <= '0;
      stage_pulse <= '0;
      done        <= 1'b0;
      blank_q     <= '0;
    end else begin
      stage_pulse <= seq_edge ? (4'b0001 << stage_q) : 4'b0000;
      if (!en) begin
        stage_q <= '0;
        done    <= 1'b0;
        blank_q <= '0;
      end else begin
        if (seq_edge) stage_q <= stage_q + 2'd1;
        if (last_step) done <= 1'b1;
        if (seq_edge && stage_q == 2'd0) blank_q <= blank_len;
        else if (blanking)               blank_q <= blank_q - BLANK_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lmfc_q <= '0;
    else if (last_step) lmfc_q <= '0;
    else if (lmfc_last) lmfc_q <= '0;
    else                lmfc_q <= lmfc_q + PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_live  <= 1'b0;
      phase_err   <= 1'b0;
      ignored_cnt <= '0;
    end else begin
      if (mon_edge) phase_live <= ~lmfc_last;
      if (mon_edge && !lmfc_last) phase_err <= 1'b1;
      else if (err_clr)           phase_err <= 1'b0;
      if (ign_edge && ignored_cnt != IGN_MAX) ignored_cnt <= ignored_cnt + IGN_W'(1);
    end
  end

endmodule

// File: rtl/sysref_sync_seq_chk.sv
module sysref_sync_seq_chk #(
  parameter int IGN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             err_clr,
  input logic [3:0]       stage_pulse,
  input logic             done,
  input logic             lmfc_tick,
  input logic             phase_err,
  input logic [IGN_W-1:0] ignored_cnt
);

  assert_pulse_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stage_pulse));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_pulse != 4'b0000) |=> (stage_pulse == 4'b0000));

  assert_ignored_saturates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ignored_cnt == '1) |=> (ignored_cnt == '1));

  assert_done_with_step4_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> stage_pulse[3]);

  assert_tick_at_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stage_pulse[3] |-> lmfc_tick);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_err && !err_clr) |=> phase_err);

  assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!done && stage_pulse == 4'b0000));

  assert_quiet_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> (stage_pulse == 4'b0000));

endmodule

bind sysref_sync_seq sysref_sync_seq_chk #(.IGN_W(IGN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .err_clr(err_clr),
  .stage_pulse(stage_pulse), .done(done), .lmfc_tick(lmfc_tick),
  .phase_err(phase_err), .ignored_cnt(ignored_cnt)
);

// File: tb/sysref_sync_seq_test.sv
module sysref_sync_seq_test;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, sysref_in = 1'b0, err_clr = 1'b0;
  logic [7:0]  lmfc_period = 8'd10;
  logic [11:0] blank_len = 12'd20;
  logic [3:0]  stage_pulse;
  logic        done, lmfc_tick, phase_live, phase_err;
  logic [3:0]  ignored_cnt;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sysref_sync_seq uut (
    .clk(clk), .rst_n(rst_n), .en(en), .sysref_in(sysref_in),
    .lmfc_period(lmfc_period), .blank_len(blank_len), .err_clr(err_clr),
    .stage_pulse(stage_pulse), .done(done), .lmfc_tick(lmfc_tick),
    .phase_live(phase_live), .phase_err(phase_err), .ignored_cnt(ignored_cnt)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fire(int exp_pulse, string req);
    sysref_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(req, stage_pulse, exp_pulse);
    sysref_in = 1'b0;
    @(negedge clk);
    chk({req, " width"}, stage_pulse, 0);
  endtask

  task automatic t_reset;
    chk("R1 pulse", stage_pulse, 0);
    chk("R1 done", done, 0);
    chk("R1 tick", lmfc_tick, 0);
    chk("R1 live", phase_live, 0);
    chk("R1 err", phase_err, 0);
    chk("R1 ign", ignored_cnt, 0);
  endtask

  task automatic t_steps_and_blanking;
    en = 1'b1;
    @(negedge clk);
    sysref_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 step1", stage_pulse, 1);
    sysref_in = 1'b0;
    @(negedge clk);
    sysref_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 blanked", stage_pulse, 0);
    chk("R4 ign count", ignored_cnt, 1);
    sysref_in = 1'b0;
    repeat (30) @(negedge clk);
    begin
      int extra = 0;
      sysref_in = 1'b1;
      repeat (3) @(negedge clk);
      chk("R2 step2", stage_pulse, 2);
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (stage_pulse != 0) extra++;
      end
      chk("R3 held level", extra, 0);
      sysref_in = 1'b0;
      @(negedge clk);
    end
    fire(4, "R2 step3");
    chk("R5 not yet done", done, 0);
  endtask

  task automatic t_align_and_phase;
    sysref_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 step4", stage_pulse, 8);
    chk("R5 done", done, 1);
    chk("R6 tick at align", lmfc_tick, 1);
    sysref_in = 1'b0;
    @(negedge clk);
    chk("R6 tick off", lmfc_tick, 0);
    repeat (6) @(negedge clk);
    sysref_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 tick period", lmfc_tick, 1);
    chk("R7 in phase live", phase_live, 0);
    chk("R7 in phase err", phase_err, 0);
    chk("R10 no pulse", stage_pulse, 0);
    sysref_in = 1'b0;
    repeat (2) @(negedge clk);
    sysref_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 off phase live", phase_live, 1);
    chk("R7 off phase err", phase_err, 1);
    chk("R10 no pulse late", stage_pulse, 0);
    chk("R5 done held", done, 1);
    sysref_in = 1'b0;
    repeat (2) @(negedge clk);
    sysref_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 back in phase", phase_live, 0);
    chk("R8 sticky", phase_err, 1);
    sysref_in = 1'b0;
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R8 cleared", phase_err, 0);
  endtask

  task automatic t_disable_restart;
    en = 1'b0;
    @(negedge clk);
    chk("R9 done cleared", done, 0);
    sysref_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 no pulse disabled", stage_pulse, 0);
    sysref_in = 1'b0;
    blank_len = 12'd200;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    fire(1, "R9 restart step1");
    for (int i = 0; i < 20; i++) begin
      sysref_in = 1'b1;
      @(negedge clk);
      sysref_in = 1'b0;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk("R4 saturation", ignored_cnt, 15);
    chk("R4 no pulse", stage_pulse, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_steps_and_blanking();
    t_align_and_phase();
    t_disable_restart();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule